// File: doc/BRIEF.md
# Four-Lane Multiply-Accumulate with Pipelined Reduction

This block is the arithmetic core of a long time-multiplexed FIR filter. The sample delay line and the coefficient store sit outside it. Every clock they present four signed samples and the four coefficients that go with them. Each of four lanes multiplies its pair and accumulates the product over one frame of `FRAME_LEN` clocks. With the defaults, four lanes times 256 clocks gives 1024 taps.

A frame is marked by a single-cycle strobe on its first clock. A delayed copy of that strobe does two things at the same edge. It captures the four finished lane sums into holding registers, and it restarts every accumulator with the first product of the new frame. No clock is spent on clearing. The held sums then pass through a two-level pipelined adder, first in pairs and then the two pair sums. The full-precision filter output is presented with a one-cycle valid pulse, so there is one result per frame.

Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `quad_mac_reduce`

## Requirements
- R1: After reset, `result_o` is 0 and `result_valid_o` is 0.
- R2: The result for a frame equals the exact sum, over every clock of that frame and every lane l from 0 to 3, of the signed product of `sample_i[16*l +: 16]` and `coef_i[16*l +: 16]`. Samples and coefficients are two's complement.
- R3: The clock on which `frame_start_i` is high belongs to the new frame. Its products are counted in the new frame and not in the old one, and no clock of data is dropped at the boundary.
- R4: The result of frame k is presented with `result_valid_o` high in the cycle that follows the third rising edge after the edge that samples the strobe of frame k+1.
- R5: The strobe of the first frame after reset produces no valid pulse.
- R6: `result_valid_o` is high for exactly one cycle per result, and `result_o` does not change while `result_valid_o` is low.
- R7: `result_o` has ACC_W = DATA_W + COEF_W + log2(4*FRAME_LEN) bits, so the output does not overflow even when every product in a frame has the largest magnitude, for example (-32768)*(-32768).
- R8: Over successive frames, when each frame carries a single sample of value 1 and zeros elsewhere, the outputs reproduce, in order, the coefficient presented with that sample in each frame, whatever its lane and clock position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | High on the first clock of each frame |
| sample_i | input | 4*DATA_W | Four signed samples, lane l at bits [DATA_W*l +: DATA_W] |
| coef_i | input | 4*COEF_W | Four signed coefficients, lane l at bits [COEF_W*l +: COEF_W] |
| result_o | output | ACC_W | Signed full-precision filter output |
| result_valid_o | output | 1 | One-cycle pulse when result_o is new |

## Verification
Two cases are the hardest to reach from the ports. The first is the frame seam, where an accumulator must drop its old total and start from the first product of the new frame within one edge. The second is the worst-case magnitude that the accumulator width must absorb. The bench runs with a short frame and places a lone nonzero product at every lane and every clock position in turn, including the strobe clock and the last clock. The outputs must then replay the coefficient sequence exactly. Frames in which every product is (-32768)*(-32768), or a mix of the extreme values, push the sum to the edge of the output width, and randomly filled frames cover the general case.

// File: rtl/qmr_pkg.sv
package qmr_pkg;
  localparam int LANES = 4;

  function automatic int acc_width(input int data_w, input int coef_w, input int frame_len);
    return data_w + coef_w + $clog2(frame_len * LANES);
  endfunction
endpackage

// File: rtl/qmr_timing.sv
module qmr_timing (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic load_o,
  output logic latch_o
);
  logic strobe_d1_q;
  logic primed_q, primed_d;

  always_comb begin
    primed_d = primed_q | strobe_d1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d1_q <= 1'b0;
      primed_q    <= 1'b0;
    end else begin
      strobe_d1_q <= strobe_i;
      primed_q    <= primed_d;
    end
  end

  assign load_o  = strobe_d1_q;
  assign latch_o = strobe_d1_q & primed_q;
endmodule

// File: rtl/qmr_lane.sv
module qmr_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 42
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic signed [COEF_W-1:0] cof_i,
  input  logic                     load_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_d, acc_q;

  always_comb begin
    prod_d   = smp_i * cof_i;
    prod_ext = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
    if (load_i) acc_d = prod_ext;
    else        acc_d = acc_q + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      prod_q <= prod_d;
      acc_q  <= acc_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/qmr_tree.sv
module qmr_tree #(
  parameter int ACC_W = 42
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            latch_i,
  input  logic [qmr_pkg::LANES*ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0]         sum_o,
  output logic                            valid_o
);
  localparam int LANES = qmr_pkg::LANES;
  localparam int PAIRS = LANES / 2;

  logic signed [ACC_W-1:0] hold_q [LANES];
  logic signed [ACC_W-1:0] hold_d [LANES];
  logic signed [ACC_W-1:0] pair_q [PAIRS];
  logic signed [ACC_W-1:0] pair_d [PAIRS];
  logic signed [ACC_W-1:0] sum_q, sum_d;
  logic hold_vld_q, pair_vld_q, sum_vld_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) hold_d[l] = acc_i[ACC_W*l +: ACC_W];
    for (int p = 0; p < PAIRS; p++) pair_d[p] = hold_q[2*p] + hold_q[2*p+1];
    sum_d = pair_q[0] + pair_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) hold_q[l] <= '0;
    end else if (latch_i) begin
      for (int l = 0; l < LANES; l++) hold_q[l] <= hold_d[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAIRS; p++) pair_q[p] <= '0;
    end else if (hold_vld_q) begin
      for (int p = 0; p < PAIRS; p++) pair_q[p] <= pair_d[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sum_q <= '0;
    else if (pair_vld_q) sum_q <= sum_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      pair_vld_q <= 1'b0;
      sum_vld_q  <= 1'b0;
    end else begin
      hold_vld_q <= latch_i;
      pair_vld_q <= hold_vld_q;
      sum_vld_q  <= pair_vld_q;
    end
  end

  assign sum_o   = sum_q;
  assign valid_o = sum_vld_q;
endmodule

// File: rtl/quad_mac_reduce.sv
module quad_mac_reduce #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int FRAME_LEN = 256,
  localparam int LANES    = qmr_pkg::LANES,
  localparam int ACC_W    = qmr_pkg::acc_width(DATA_W, COEF_W, FRAME_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start_i,
  input  logic [LANES*DATA_W-1:0]   sample_i,
  input  logic [LANES*COEF_W-1:0]   coef_i,
  output logic signed [ACC_W-1:0]   result_o,
  output logic                      result_valid_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       load, latch;
  logic [LANES*ACC_W-1:0] acc_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  qmr_timing u_timing (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .strobe_i (frame_start_i),
    .load_o   (load),
    .latch_o  (latch)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACC_W-1:0] lane_acc;
    qmr_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .smp_i  (sample_i[DATA_W*l +: DATA_W]),
      .cof_i  (coef_i[COEF_W*l +: COEF_W]),
      .load_i (load),
      .acc_o  (lane_acc)
    );
    assign acc_bus[ACC_W*l +: ACC_W] = lane_acc;
  end

  qmr_tree #(.ACC_W(ACC_W)) u_tree (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .latch_i (latch),
    .acc_i   (acc_bus),
    .sum_o   (result_o),
    .valid_o (result_valid_o)
  );
endmodule

// File: rtl/qmr_checker.sv
module qmr_checker #(
  parameter int ACC_W = 42
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start_i,
  input logic [ACC_W-1:0] result_o,
  input logic             result_valid_o
);
  logic [1:0] strobes_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobes_seen_q <= 2'd0;
    else if (frame_start_i && strobes_seen_q != 2'd2) strobes_seen_q <= strobes_seen_q + 2'd1;
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o));

  // R4
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(frame_start_i, 4));

  // R5
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (strobes_seen_q == 2'd2));

  // R3
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> !frame_start_i);
endmodule

bind quad_mac_reduce qmr_checker #(.ACC_W(ACC_W)) u_qmr_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start_i  (frame_start_i),
  .result_o       (result_o),
  .result_valid_o (result_valid_o)
);

// File: tb/quad_mac_reduce_bench.sv
module quad_mac_reduce_bench;
  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int FLEN   = 8;
  localparam int LANES  = 4;
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(FLEN * LANES);

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start;
  logic [LANES*DATA_W-1:0] smp_bus;
  logic [LANES*COEF_W-1:0] cof_bus;
  logic signed [ACC_W-1:0] result;
  logic result_valid;

  int n_checks = 0;
  int n_fail   = 0;
  longint exp_q[$];
  string  tag_q[$];
  logic [3:0] hist;
  logic seen;
  logic signed [ACC_W-1:0] last_result;
  logic mon_on = 1'b0;

  always #5 clk = ~clk;

  quad_mac_reduce #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAME_LEN(FLEN)) u_quad_mac_reduce (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .sample_i(smp_bus), .coef_i(cof_bus),
    .result_o(result), .result_valid_o(result_valid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      seen <= 1'b0;
    end else begin
      hist <= {hist[2:0], frame_start & seen};
      seen <= seen | frame_start;
    end
  end

  // Output monitor: valid timing (R4, R5), hold (R6), values (R2, R3, R7, R8)
  always @(negedge clk) begin
    if (mon_on) begin
      if (result_valid || hist[3])
        check(seen && hist[3] ? "R4 valid timing" : "R5 early valid",
              longint'(result_valid), longint'(hist[3]));
      if (result_valid) begin
        if (exp_q.size() == 0) check("R4 unexpected result", 1, 0);
        else check(tag_q.pop_front(), longint'(result), exp_q.pop_front());
      end else begin
        check("R6 hold", longint'(result), longint'(last_result));
      end
      last_result = result;
    end
  end

  // mode 0 random, 1 extreme (arg selects), 2 impulse n=arg, 3 zeros
  task automatic run_frame(input int mode, input int arg, input string tag, input bit keep);
    longint sum = 0;
    for (int c = 0; c < FLEN; c++) begin
      @(negedge clk);
      frame_start = (c == 0);
      for (int l = 0; l < LANES; l++) begin
        shortint s, k;
        case (mode)
          0: begin s = shortint'($urandom); k = shortint'($urandom); end
          1: begin
               s = (arg == 0 || arg == 1) ? -16'sd32768 : 16'sd32767;
               k = (arg == 0) ? -16'sd32768 : 16'sd32767;
             end
          2: begin
               k = shortint'($urandom);
               s = 0;
               if (l == (arg % LANES) && c == ((arg / LANES) % FLEN)) begin
                 s = 1;
                 k = shortint'(3 * arg - 40);
               end
             end
          default: begin s = 0; k = shortint'($urandom); end
        endcase
        smp_bus[DATA_W*l +: DATA_W] = s;
        cof_bus[COEF_W*l +: COEF_W] = k;
        sum += longint'(s) * longint'(k);
      end
    end
    if (keep) begin
      exp_q.push_back(sum);
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 1'b0;
    smp_bus = '0;
    cof_bus = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset result", longint'(result), 0);
    check("R1 reset valid", longint'(result_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_result = result;
    mon_on = 1'b1;
    // R2 random frames
    for (int f = 0; f < 6; f++) run_frame(0, 0, "R2 random frame", 1'b1);
    // R7 extremes
    run_frame(1, 0, "R7 min*min", 1'b1);
    run_frame(1, 1, "R7 min*max", 1'b1);
    run_frame(1, 2, "R7 max*max", 1'b1);
    // R8 / R3 impulse swept over every lane and clock slot
    for (int n = 0; n < LANES * FLEN; n++) run_frame(2, n, "R8 R3 impulse", 1'b1);
    run_frame(3, 0, "R2 zero frame", 1'b1);
    run_frame(0, 0, "R2 random frame", 1'b1);
    run_frame(3, 0, "flush", 1'b0);
    @(negedge clk);
    frame_start = 1'b0;
    repeat (8) @(negedge clk);
    check("R4 all results delivered", longint'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule